// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two unsigned operands and a carry input in a single combinational pass. It produces a sum of the same width and a carry output. Every bit first forms a propagate term (the OR of its operand bits) and a generate term (the AND of its operand bits). The bits are split into groups of four.

Inside a group, the carry into each bit comes from a fully expanded sum-of-products equation. That equation reads only the group's carry input and the propagate and generate terms of the bits below it, so no bit waits on the carry of its neighbour. Each group also reduces its terms to one group generate and one group propagate. The carry into the next group is formed from these two terms and the group's own carry input.

Because propagate is an OR, a bit where both operands are 1 has both terms set. The sum bit is therefore the XOR of the incoming carry, the propagate term and the generate term. The width is a parameter and must be a multiple of four.

Top module: `cla_adder`

## Requirements
- R1: For every pair of operands and both carry-in values, {cout, sum} equals a + b + cin taken over WIDTH+1 bits.
- R2: The carry entering each 4-bit group boundary equals the arithmetic carry out of all bits below that boundary. For example, a = 0x000F, b = 0x0001, cin = 0 yields sum 0x0010, and a = 0x0FFF, b = 0x0000, cin = 1 yields sum 0x1000.
- R3: All-ones plus zero with cin = 1 yields sum 0 and cout 1. All-ones plus all-ones with cin = 1 yields sum all-ones and cout 1.
- R4: Zero plus zero yields sum equal to cin in bit 0 with all other bits 0, and cout 0.
- R5: When b is the bitwise inverse of a (for example, alternating patterns 0xAAAA and 0x5555), sum is all-ones and cout is 0 for cin = 0. For cin = 1, sum is 0 and cout is 1.
- R6: When the top bits of a and b are both 1, cout is 1 whatever the lower bits and cin are.
- R7: A configuration with WIDTH = 8 (two groups) meets R1 over its full operand space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top group |

## Verification
Within one evaluation, a group can both generate a carry internally and pass through a carry arriving from the group below. The bench provokes this overlap with boundary patterns such as 0x0FFF + 0 + 1 and 0x000F + 1. It also provokes it with the alternating patterns, where every bit propagates, and with operands whose top bits both generate. The two-group 8-bit configuration is swept over all operand pairs and both carry-in values. Every result is judged against a + b + cin computed arithmetically in the bench.

// File: rtl/cla_pkg.sv
`timescale 1ns/1ps
package cla_pkg;
  // bits covered by one expanded lookahead unit
  localparam int unsigned GRP_BITS = 4;

  // reduced terms of one group
  typedef struct packed {
    logic gen;
    logic prop;
  } grp_terms_t;
endpackage

// File: rtl/cla_pg_stage.sv
`timescale 1ns/1ps
module cla_pg_stage #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] gen
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // propagate is the inclusive OR, generate the AND
    assign prop[i] = op_a[i] | op_b[i];
    assign gen[i]  = op_a[i] & op_b[i];
  end
endmodule

// File: rtl/cla_group4.sv
`timescale 1ns/1ps
module cla_group4
  import cla_pkg::*;
(
  input  logic       [3:0] prop,
  input  logic       [3:0] gen,
  input  logic             c_in,
  output logic       [3:0] c_bit,
  output grp_terms_t       terms
);
  // every carry expanded down to c_in; no intermediate carry is reused
  always_comb begin
    c_bit[0] = c_in;
    c_bit[1] = gen[0]
             | (prop[0] & c_in);
    c_bit[2] = gen[1]
             | (prop[1] & gen[0])
             | (prop[1] & prop[0] & c_in);
    c_bit[3] = gen[2]
             | (prop[2] & gen[1])
             | (prop[2] & prop[1] & gen[0])
             | (prop[2] & prop[1] & prop[0] & c_in);
    terms.gen  = gen[3]
               | (prop[3] & gen[2])
               | (prop[3] & prop[2] & gen[1])
               | (prop[3] & prop[2] & prop[1] & gen[0]);
    terms.prop = &prop;
  end
endmodule

// File: rtl/cla_sum_stage.sv
`timescale 1ns/1ps
module cla_sum_stage #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] c_bit,
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] sum
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // with OR-propagate, a^b equals prop^gen
    assign sum[i] = c_bit[i] ^ prop[i] ^ gen[i];
  end
endmodule

// File: rtl/cla_adder.sv
`timescale 1ns/1ps
module cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int unsigned NGRP = WIDTH / GRP_BITS;

  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] c_bit;
  logic [NGRP:0]    c_grp;
  grp_terms_t       terms [NGRP];

  cla_pg_stage #(.WIDTH(WIDTH)) u_pg (
    .op_a (a),
    .op_b (b),
    .prop (prop),
    .gen  (gen)
  );

  assign c_grp[0] = cin;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    cla_group4 u_grp (
      .prop  (prop[k*GRP_BITS +: GRP_BITS]),
      .gen   (gen[k*GRP_BITS +: GRP_BITS]),
      .c_in  (c_grp[k]),
      .c_bit (c_bit[k*GRP_BITS +: GRP_BITS]),
      .terms (terms[k])
    );
    // group carries chain from the reduced group terms
    assign c_grp[k+1] = terms[k].gen | (terms[k].prop & c_grp[k]);
  end

  cla_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .c_bit (c_bit),
    .prop  (prop),
    .gen   (gen),
    .sum   (sum)
  );

  assign cout = c_grp[NGRP];
endmodule

// File: rtl/cla_adder_checker.sv
`timescale 1ns/1ps
module cla_adder_checker #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned NGRP  = WIDTH / 4
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NGRP:0]    c_grp
);
  logic [WIDTH:0] ref_total;
  logic [WIDTH:0] msk;
  logic [WIDTH:0] part;

  assign ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    assert_sum_exact_R1: assert ({cout, sum} == ref_total);
    if (a == {WIDTH{1'b1}} && b == '0 && cin) begin
      assert_ones_wrap_R3: assert (sum == '0 && cout);
    end
    if (a == '0 && b == '0) begin
      assert_zero_in_R4: assert (sum == {{(WIDTH-1){1'b0}}, cin} && !cout);
    end
    if (b == ~a) begin
      assert_inverse_R5: assert (sum == {WIDTH{~cin}} && cout == cin);
    end
    if (a[WIDTH-1] && b[WIDTH-1]) begin
      assert_top_gen_R6: assert (cout);
    end
  end

  // carry at each group boundary against the arithmetic carry of the bits below
  always_comb begin
    msk  = '0;
    part = '0;
    for (int k = 1; k <= int'(NGRP); k++) begin
      msk  = ({{WIDTH{1'b0}}, 1'b1} << (k*4)) - 1'b1;
      part = ({1'b0, a} & msk) + ({1'b0, b} & msk) + {{WIDTH{1'b0}}, cin};
      assert_grp_carry_R2: assert (c_grp[k] == part[k*4]);
    end
  end
endmodule

bind cla_adder cla_adder_checker #(.WIDTH(WIDTH), .NGRP(NGRP)) u_chk (
  .a     (a),
  .b     (b),
  .cin   (cin),
  .sum   (sum),
  .cout  (cout),
  .c_grp (c_grp)
);

// File: tb/cla_adder_test.sv
`timescale 1ns/1ps
module cla_adder_test;
  localparam int unsigned W  = 16;
  localparam int unsigned WS = 8;
  localparam int unsigned WATCHDOG = 150000;

  logic clk;
  logic rst_n;
  int   n_run;
  int   n_fail;
  int   cyc;
  bit   done;

  logic [W-1:0]  a, b, sum;
  logic          cin, cout;
  logic [WS-1:0] as, bs, sums;
  logic          cins, couts;

  cla_adder #(.WIDTH(W)) uut (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  cla_adder #(.WIDTH(WS)) uut_small (
    .a(as), .b(bs), .cin(cins), .sum(sums), .cout(couts)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!done && rst_n && cyc >= WATCHDOG) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: cycle %0d, expected finish before %0d", cyc, WATCHDOG);
      report();
    end
  end

  // drive, settle, sample away from the clock edge
  task automatic chk16(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic ci, input string req);
    logic [W:0] exp_v;
    a = x; b = y; cin = ci;
    #1;
    exp_v = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    n_run++;
    if ({cout, sum} !== exp_v) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h cin=%b actual=%h expected=%h",
               req, x, y, ci, {cout, sum}, exp_v);
    end
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    a = '0; b = '0; cin = 1'b0;
    as = '0; bs = '0; cins = 1'b0;
    rst_n = 1'b0;
    #10 rst_n = 1'b1;

    // R4: zero operands
    chk16(16'h0000, 16'h0000, 1'b0, "R4");
    chk16(16'h0000, 16'h0000, 1'b1, "R4");
    // R3: all ones
    chk16(16'hFFFF, 16'h0000, 1'b1, "R3");
    chk16(16'hFFFF, 16'hFFFF, 1'b1, "R3");
    chk16(16'hFFFF, 16'h0000, 1'b0, "R3");
    // R5: alternating and inverse patterns
    chk16(16'hAAAA, 16'h5555, 1'b0, "R5");
    chk16(16'hAAAA, 16'h5555, 1'b1, "R5");
    chk16(16'h5555, 16'hAAAA, 1'b1, "R5");
    chk16(16'h0F0F, 16'hF0F0, 1'b1, "R5");
    chk16(16'hAAAA, 16'hAAAA, 1'b0, "R1");
    chk16(16'h5555, 16'h5555, 1'b1, "R1");
    // R2: carries crossing group boundaries
    chk16(16'h000F, 16'h0001, 1'b0, "R2");
    chk16(16'h0FFF, 16'h0000, 1'b1, "R2");
    chk16(16'h00F0, 16'h0010, 1'b0, "R2");
    chk16(16'h0F00, 16'h0100, 1'b1, "R2");
    chk16(16'h0008, 16'h0008, 1'b0, "R2");
    chk16(16'h0888, 16'h0888, 1'b1, "R2");
    // R6: top-bit generate
    chk16(16'h8000, 16'h8000, 1'b0, "R6");
    chk16(16'h8123, 16'hC000, 1'b1, "R6");
    // R1: walking ones and random operands
    for (int i = 0; i < int'(W); i++) begin
      chk16(16'(1 << i), 16'(1 << i), 1'b0, "R1");
      chk16(16'(1 << i), 16'hFFFF, 1'b1, "R1");
    end
    for (int i = 0; i < 2000; i++) begin
      chk16(16'($urandom), 16'($urandom), 1'($urandom), "R1");
    end

    // R7: exhaustive sweep of the two-group configuration
    for (int ci = 0; ci < 2; ci++) begin
      for (int x = 0; x < (1 << WS); x++) begin
        for (int y = 0; y < (1 << WS); y++) begin
          logic [WS:0] exp_s;
          as = WS'(x); bs = WS'(y); cins = 1'(ci);
          #1;
          exp_s = (WS+1)'(x + y + ci);
          n_run++;
          if ({couts, sums} !== exp_s) begin
            n_fail++;
            $display("FAIL R7: a=%h b=%h cin=%0d actual=%h expected=%h",
                     as, bs, ci, {couts, sums}, exp_s);
          end
        end
      end
    end

    done = 1'b1;
    report();
  end
endmodule